// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block supplies the column address for every data beat of a synchronous DRAM burst. When a read or write is accepted, it captures the starting column of a 512-column page, the burst length code and the ordering (linear or interleaved). From the next cycle on it presents one column per clock. Each column stays inside the block of columns, aligned to the burst length, that holds the starting column. A page-length burst runs linearly around the whole page until something stops it.

A memory controller or a DRAM model uses the block next to its command decoder. It drives `start_i` for every accepted read or write, `stop_i` for a burst stop (or a precharge that ends the burst), and `cke_i` with the clock-enable level. The outputs show whether a beat is active this cycle, its column, and whether it is the final beat of a fixed-length burst.

Top module: `sdram_burst_colgen`

## Requirements
- R1: While reset is asserted and after it is released with no start, `valid_o` and `last_o` are 0.
- R2: A start accepted at a clock edge makes `valid_o` 1 from the next cycle, and that first beat shows `start_col_i`.
- R3: The length code `blen_i` selects 1 beat (0), 2 beats (1), 4 beats (2), 8 beats (3) or a full page (7). The reserved codes 4, 5 and 6 give a single beat.
- R4: With `order_i`=0 (linear), beat k shows the starting column's aligned block base plus ((start offset within the block + k) modulo the length). The upper column bits never change.
- R5: With `order_i`=1 (interleaved), beat k shows the start column XOR k. For length 8 and start 2 the beats are 2, 3, 0, 1, 6, 7, 4, 5.
- R6: A full-page burst always runs in linear order, whatever `order_i` is. It goes from column 511 to column 0 and continues until a stop or a new start. `last_o` is never 1 during it.
- R7: `last_o` is 1 exactly on the final beat of a fixed-length burst. `valid_o` drops in the following cycle unless a new start was accepted.
- R8: A start accepted during a burst drops the remaining beats. A new burst of full length begins from the new column in the next cycle, and a start may be accepted on every clock.
- R9: An accepted stop ends the burst: `valid_o` is 0 from the next cycle. If start and stop arrive in the same cycle, the start wins.
- R10: `cke_i` low sampled at one edge freezes the sequence from the following edge on. The sequence resumes one edge after `cke_i` is sampled high again. Start and stop are ignored on frozen edges, and the frozen beat stays on the outputs.
- R11: Length and order are captured at the start. Changing `blen_i` or `order_i` during a burst has no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke_i | input | 1 | Clock-enable level; low suspends the sequence with one clock of latency |
| start_i | input | 1 | Read or write accepted; begins a new burst |
| start_col_i | input | 9 | Starting column for the new burst |
| blen_i | input | 3 | Burst length code (see R3) |
| order_i | input | 1 | 0 linear, 1 interleaved |
| stop_i | input | 1 | Terminates the running burst |
| col_o | output | 9 | Column for the current beat |
| valid_o | output | 1 | A beat is active this cycle |
| last_o | output | 1 | Current beat is the final one of a fixed-length burst |

## Verification
On every cycle the assertions check the following: each beat stays in its aligned block, a final beat closes the burst, a stop closes it, a start reopens it at beat zero, the state holds while suspended, and a page burst wraps from 511 to 0. Only the bench's scenarios can show the exact column orders: linear and interleaved for each length, the interleaved example sequence, the reserved length codes, and a full page of more than 512 beats. The bench scenarios also cover the one-clock latency of suspend entry and exit, starts and stops ignored while suspended, and settings changed in the middle of a burst.

// File: rtl/colgen_pkg.sv
package colgen_pkg;

  typedef enum logic [2:0] {
    BLEN_1    = 3'd0,
    BLEN_2    = 3'd1,
    BLEN_4    = 3'd2,
    BLEN_8    = 3'd3,
    BLEN_PAGE = 3'd7
  } blen_code_e;

  typedef enum logic {
    ORD_LINEAR = 1'b0,
    ORD_XOR    = 1'b1
  } burst_order_e;

endpackage

// File: rtl/colgen_len_decode.sv
module colgen_len_decode
  import colgen_pkg::*;
#(
  parameter int COL_W    = 9,
  parameter int MAX_LOG2 = 3
) (
  input  logic [2:0]       code_i,
  output logic [COL_W-1:0] mask_o,
  output logic             page_o
);

  localparam logic [2:0] MAX_CODE = 3'(MAX_LOG2);

  // one candidate mask per fixed length, chosen by the code
  logic [COL_W-1:0] fixed_mask [MAX_LOG2+1];

  for (genvar g = 0; g <= MAX_LOG2; g++) begin : g_len
    assign fixed_mask[g] = COL_W'((1 << g) - 1);
  end

  always_comb begin
    mask_o = '0;
    page_o = 1'b0;
    if (code_i == BLEN_PAGE) begin
      mask_o = '1;
      page_o = 1'b1;
    end else if (code_i <= MAX_CODE) begin
      mask_o = fixed_mask[code_i];
    end
  end

endmodule

// File: rtl/colgen_addr.sv
module colgen_addr #(
  parameter int COL_W = 9
) (
  input  logic [COL_W-1:0] base_i,
  input  logic [COL_W-1:0] cnt_i,
  input  logic [COL_W-1:0] mask_i,
  input  logic             xor_i,
  input  logic             page_i,
  output logic [COL_W-1:0] col_o
);

  logic [COL_W-1:0] step;
  logic [COL_W-1:0] sum;
  logic [COL_W-1:0] lin_col;
  logic [COL_W-1:0] xor_col;

  always_comb begin
    step    = cnt_i & mask_i;
    sum     = base_i + step;
    lin_col = (base_i & ~mask_i) | (sum & mask_i);
    xor_col = base_i ^ step;
    col_o   = (xor_i && !page_i) ? xor_col : lin_col;
  end

endmodule

// File: rtl/colgen_ctrl.sv
module colgen_ctrl #(
  parameter int COL_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cke_i,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic [COL_W-1:0] start_col_i,
  input  logic [COL_W-1:0] mask_i,
  input  logic             page_i,
  input  logic             xor_i,
  output logic             active_o,
  output logic             run_o,
  output logic [COL_W-1:0] cnt_o,
  output logic [COL_W-1:0] base_o,
  output logic [COL_W-1:0] mask_o,
  output logic             page_o,
  output logic             xor_o,
  output logic             last_o
);

  logic             active_q, active_d;
  logic             cke_q;
  logic [COL_W-1:0] cnt_q, cnt_d;
  logic [COL_W-1:0] base_q, mask_q;
  logic             page_q, xor_q;
  logic             take_start, take_stop, cfg_en;

  // commands and advancement use the clock enable delayed by one edge
  always_comb begin
    take_start = start_i & cke_q;
    take_stop  = stop_i & cke_q & ~start_i;
    cfg_en     = take_start;
    last_o     = active_q & ~page_q & (cnt_q == mask_q);
    active_d   = active_q;
    cnt_d      = cnt_q;
    if (take_start) begin
      active_d = 1'b1;
      cnt_d    = '0;
    end else if (take_stop) begin
      active_d = 1'b0;
    end else if (cke_q && active_q) begin
      if (last_o) active_d = 1'b0;
      else        cnt_d    = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      cke_q    <= 1'b1;
    end else begin
      active_q <= active_d;
      cnt_q    <= cnt_d;
      cke_q    <= cke_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      mask_q <= '0;
      page_q <= 1'b0;
      xor_q  <= 1'b0;
    end else if (cfg_en) begin
      base_q <= start_col_i;
      mask_q <= mask_i;
      page_q <= page_i;
      xor_q  <= xor_i;
    end
  end

  assign active_o = active_q;
  assign run_o    = cke_q;
  assign cnt_o    = cnt_q;
  assign base_o   = base_q;
  assign mask_o   = mask_q;
  assign page_o   = page_q;
  assign xor_o    = xor_q;

  // R2 / R8: accepted start opens a burst at beat zero
  p_start_opens_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && cke_q) |=> (active_q && cnt_q == '0));

  // R9: accepted stop without start closes the burst
  p_stop_closes_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_i && !start_i && cke_q) |=> !active_q);

  // R7: a final beat that advances closes the burst
  p_last_closes_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (last_o && cke_q && !start_i) |=> !active_q);

  // R10: suspended edge keeps all sequence state
  p_suspend_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !cke_q |=> ($stable(active_q) && $stable(cnt_q) && $stable(base_q)));

endmodule

// File: rtl/sdram_burst_colgen.sv
module sdram_burst_colgen #(
  parameter int COL_W    = 9,
  parameter int MAX_LOG2 = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cke_i,
  input  logic             start_i,
  input  logic [COL_W-1:0] start_col_i,
  input  logic [2:0]       blen_i,
  input  logic             order_i,
  input  logic             stop_i,
  output logic [COL_W-1:0] col_o,
  output logic             valid_o,
  output logic             last_o
);

  logic [COL_W-1:0] dec_mask, cnt, base, mask;
  logic             dec_page, page, xor_sel, run;

  colgen_len_decode #(.COL_W(COL_W), .MAX_LOG2(MAX_LOG2)) u_dec (
    .code_i (blen_i),
    .mask_o (dec_mask),
    .page_o (dec_page)
  );

  colgen_ctrl #(.COL_W(COL_W)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .cke_i       (cke_i),
    .start_i     (start_i),
    .stop_i      (stop_i),
    .start_col_i (start_col_i),
    .mask_i      (dec_mask),
    .page_i      (dec_page),
    .xor_i       (order_i),
    .active_o    (valid_o),
    .run_o       (run),
    .cnt_o       (cnt),
    .base_o      (base),
    .mask_o      (mask),
    .page_o      (page),
    .xor_o       (xor_sel),
    .last_o      (last_o)
  );

  colgen_addr #(.COL_W(COL_W)) u_addr (
    .base_i (base),
    .cnt_i  (cnt),
    .mask_i (mask),
    .xor_i  (xor_sel),
    .page_i (page),
    .col_o  (col_o)
  );

  // R4 / R5: every beat lies in the aligned block of the start column
  p_in_block_r4: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> (((col_o ^ base) & ~mask) == '0));

  // R6: a running page burst steps from the top column back to zero
  p_page_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && page && run && !start_i && !stop_i && col_o == '1)
      |=> (valid_o && col_o == '0));

  // R6: no final-beat flag while a page burst runs
  p_page_no_last_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && page) |-> !last_o);

endmodule

// File: tb/tb_sdram_burst_colgen.sv
module tb_sdram_burst_colgen;

  localparam int CLK_P = 10;

  typedef struct {
    logic       valid;
    logic       last;
    logic [8:0] col;
    string      tag;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cke_i = 1'b1;
  logic       start_i = 1'b0;
  logic [8:0] start_col_i = '0;
  logic [2:0] blen_i = '0;
  logic       order_i = 1'b0;
  logic       stop_i = 1'b0;
  logic [8:0] col_o;
  logic       valid_o, last_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  exp_t       sb[$];
  logic [8:0] hist[$];

  // reference state, from the requirements
  bit      m_act = 0;
  bit      m_ckq = 1;
  int      m_cnt = 0;
  int      m_base = 0;
  int      m_len = 1;
  bit      m_page = 0;
  bit      m_xor = 0;

  always #(CLK_P/2) clk = ~clk;

  sdram_burst_colgen dut (
    .clk(clk), .rst_n(rst_n), .cke_i(cke_i), .start_i(start_i),
    .start_col_i(start_col_i), .blen_i(blen_i), .order_i(order_i),
    .stop_i(stop_i), .col_o(col_o), .valid_o(valid_o), .last_o(last_o)
  );

  function automatic int len_of(input logic [2:0] code);
    case (code)
      3'd0: return 1;
      3'd1: return 2;
      3'd2: return 4;
      3'd3: return 8;
      3'd7: return 512;
      default: return 1;
    endcase
  endfunction

  function automatic exp_t model_out(input string tag);
    exp_t e;
    int blk;
    e.tag   = tag;
    e.valid = m_act;
    e.last  = m_act && !m_page && (m_cnt == m_len - 1);
    if (m_xor && !m_page) e.col = 9'(m_base ^ m_cnt);
    else begin
      blk   = (m_base / m_len) * m_len;
      e.col = 9'(blk + ((m_base % m_len) + m_cnt) % m_len);
    end
    return e;
  endfunction

  task automatic check(input string tag, input logic [8:0] act,
                       input logic [8:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // driver: called at a falling edge, pushes the output expected after the next rising edge
  task automatic step(input logic st, input logic [8:0] c, input logic [2:0] bl,
                      input logic ord, input logic sp, input logic ck, input string tag);
    start_i = st; start_col_i = c; blen_i = bl; order_i = ord; stop_i = sp; cke_i = ck;
    if (m_ckq) begin
      if (st) begin
        m_act = 1; m_cnt = 0; m_base = int'(c); m_len = len_of(bl);
        m_page = (bl == 3'd7); m_xor = ord;
      end else if (sp) begin
        m_act = 0;
      end else if (m_act) begin
        if (!m_page && m_cnt == m_len - 1) m_act = 0;
        else m_cnt = (m_cnt + 1) % 512;
      end
    end
    m_ckq = ck;
    sb.push_back(model_out(tag));
    @(negedge clk);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(0, 9'd0, 3'd0, 0, 0, 1, tag);
  endtask

  // monitor: compares after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #(CLK_P/4);
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        check(e.tag, 9'(valid_o), 9'(e.valid), "valid");
        check(e.tag, 9'(last_o), 9'(e.last), "last");
        if (e.valid) begin
          check(e.tag, col_o, e.col, "col");
          hist.push_back(col_o);
        end
      end
    end
  end

  initial begin
    #(CLK_P * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [8:0] r5_seq [8] = '{9'd2, 9'd3, 9'd0, 9'd1, 9'd6, 9'd7, 9'd4, 9'd5};
    repeat (3) @(negedge clk);
    check("R1", 9'(valid_o), 9'd0, "valid in reset");
    check("R1", 9'(last_o), 9'd0, "last in reset");
    rst_n = 1'b1;
    idle(2, "R1");

    // R2 R3 R4: linear bursts of each fixed length
    step(1, 9'd6, 3'd2, 0, 0, 1, "R4_len4"); idle(5, "R4_len4");
    step(1, 9'd13, 3'd3, 0, 0, 1, "R4_len8"); idle(9, "R4_len8");
    step(1, 9'd101, 3'd1, 0, 0, 1, "R3_len2"); idle(3, "R3_len2");
    step(1, 9'd77, 3'd0, 0, 0, 1, "R2_len1"); idle(2, "R2_len1");
    step(1, 9'd40, 3'd5, 0, 0, 1, "R3_reserved"); idle(2, "R3_reserved");
    step(1, 9'd511, 3'd4, 1, 0, 1, "R3_reserved4"); idle(2, "R3_reserved4");

    // R5: interleaved, plus the literal example order
    hist.delete();
    step(1, 9'd2, 3'd3, 1, 0, 1, "R5_ilv8"); idle(9, "R5_ilv8");
    checks++;
    if (hist.size() != 8) begin
      fails++;
      $display("FAIL R5 beat count actual=%0d expected=8", hist.size());
    end else begin
      for (int i = 0; i < 8; i++) check("R5", hist[i], r5_seq[i], "example order");
    end
    step(1, 9'd45, 3'd2, 1, 0, 1, "R5_ilv4"); idle(5, "R5_ilv4");

    // R6: page burst with interleaved request stays linear and wraps
    step(1, 9'd508, 3'd7, 1, 0, 1, "R6_page"); idle(520, "R6_page");
    step(0, 9'd0, 3'd0, 0, 1, 1, "R9_stop_page"); idle(2, "R9_stop_page");

    // R8: restart mid-burst, and a start every clock
    step(1, 9'd16, 3'd3, 0, 0, 1, "R8"); idle(2, "R8");
    step(1, 9'd35, 3'd2, 1, 0, 1, "R8_restart");
    step(1, 9'd200, 3'd3, 0, 0, 1, "R8_back2back");
    idle(9, "R8_restart");

    // R9: stop mid-burst, then stop with start in the same cycle
    step(1, 9'd80, 3'd3, 0, 0, 1, "R9"); idle(2, "R9");
    step(0, 9'd0, 3'd0, 0, 1, 1, "R9_stop"); idle(2, "R9_stop");
    step(1, 9'd90, 3'd3, 0, 0, 1, "R9"); idle(1, "R9");
    step(1, 9'd300, 3'd2, 0, 1, 1, "R9_start_wins"); idle(5, "R9_start_wins");

    // R10: suspend latency, ignored start and stop while frozen
    step(1, 9'd0, 3'd3, 0, 0, 1, "R10"); idle(1, "R10");
    step(0, 9'd0, 3'd0, 0, 0, 0, "R10_enter");
    step(1, 9'd400, 3'd0, 0, 0, 0, "R10_start_ignored");
    step(0, 9'd0, 3'd0, 0, 1, 0, "R10_stop_ignored");
    step(0, 9'd0, 3'd0, 0, 1, 1, "R10_exit");
    idle(8, "R10_resume");

    // R11: length and order inputs changed during a burst
    step(1, 9'd50, 3'd2, 0, 0, 1, "R11");
    for (int i = 0; i < 5; i++) step(0, 9'd0, 3'd7, 1, 0, 1, "R11_cfg_change");
    idle(2, "R11");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule